// File: doc/BRIEF.md
# Multiplexed External Data Bus Controller

This block runs single read and write transfers on an 8-bit external data memory bus. The low address byte and the data take turns on one shared 8-bit port. The high address byte goes out on a second port. A high address-latch strobe opens each transfer, so that an external latch can capture the low byte before the port turns to data. A processor-side request carries the direction, the addressing form (8-bit indexed or 16-bit pointer), the two address bytes and the write data. The block answers with a busy level and a one-cycle completion pulse, and on reads it returns the sampled data with that pulse.

Timing is counted in bus clocks. A bus clock equals the block clock in double-speed mode and every second block clock in standard mode. A transfer takes six bus clocks: one with the latch strobe high, one holding the address, three with the read or write strobe low, and one recovery clock. When the stretch control is set, the strobe interval grows to fifteen bus clocks, so the whole transfer takes eighteen. The high-address port shows the port latch value for indexed accesses. For pointer accesses it shows the pointer's high byte, or the port latch value when page mode is set. Whichever value is chosen, the port holds it for the whole transfer.

The states are IDLE, ALE, ADDR, STROBE and RECOVER. The transitions are:
- IDLE to ALE when a request is accepted on a bus clock.
- ALE to ADDR after one bus clock.
- ADDR to STROBE after one bus clock, loading the strobe length.
- STROBE to RECOVER when the strobe count runs out.
- RECOVER to IDLE after one bus clock.

Top module: `xbus_ctrl`

## Requirements
- R1: During and after reset, with no request, ale is 0, rd_n and wr_n are 1, p0_oe is 0, busy and done are 0, and p2_out equals port2_latch.
- R2: An accepted normal transfer keeps busy high for 6 bus clocks. A bus clock is 1 block clock when dbl_speed=1 and 2 block clocks when dbl_speed=0.
- R3: ale is high for exactly the first bus clock of a transfer. p0_oe=1 and p0_out equals req_lo for the first two bus clocks.
- R4: The active strobe is low from bus clock 2 through bus clock 4 (3 clocks) when stretch_en=0. With stretch_en=1 it is low for 15 bus clocks, and busy then lasts 18 bus clocks.
- R5: rd_n and wr_n are never low together, and neither is low while ale is high.
- R6: On a write (req_write=1), p0_out equals req_wdata with p0_oe=1 from the end of the address phase until one bus clock after wr_n rises.
- R7: On a read, p0_oe is 0 from the start of the strobe to the end of the transfer. rdata returns the value p0_in held on the last bus clock before rd_n rises.
- R8: For an indexed access (req_wide=0), p2_out equals port2_latch as captured at acceptance.
- R9: For a pointer access (req_wide=1), p2_out equals req_hi when page_mode=0 and port2_latch when page_mode=1.
- R10: p2_out stays at the value chosen at acceptance for the whole transfer, even when port2_latch changes, including in the stretched interval.
- R11: done is high for exactly one block clock, the first clock after busy falls.
- R12: A request presented while busy is ignored: no second transfer starts after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rst | input | 1 | Synchronous reset, active high |
| dbl_speed | input | 1 | 1: bus clock = block clock; 0: block clock / 2 |
| stretch_en | input | 1 | Stretch strobe to 15 bus clocks |
| page_mode | input | 1 | Pointer accesses use port latch for high byte |
| port2_latch | input | 8 | High-port latch contents |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 pointer (16-bit), 0 indexed (8-bit) |
| req_lo | input | 8 | Low address byte |
| req_hi | input | 8 | Pointer high byte |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with done |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| p0_out | output | 8 | Shared port output value |
| p0_oe | output | 1 | Shared port output enable |
| p0_in | input | 8 | Shared port input value |
| p2_out | output | 8 | High address port |

## Verification
Every result is due at a fixed block-clock offset k from the first clock in which busy is high. A signal's bus-clock phase is k divided by the divide ratio (1 or 2). Phase 0 carries ale, phases 0 to 1 carry the address, phases 2 to 1+S carry the strobe, and phase 2+S is recovery. done and rdata are due at k = (3+S)·ratio and nowhere else. The bench samples every output on the falling edge at each k and compares it with values it works out from these offsets. On reads, it drives p0_in to the correct value only during the last strobe bus clock, so data sampled at any other time is wrong.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_ADDR,
        ST_STROBE,
        ST_RECOVER
    } xbus_state_e;

endpackage

// File: rtl/xbus_tick.sv
module xbus_tick (
    input  logic clk,
    input  logic rst,
    input  logic dbl_speed,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign tick = dbl_speed | phase_q;
endmodule

// File: rtl/xbus_hi_sel.sv
module xbus_hi_sel #(
    parameter int DW = 8
) (
    input  logic          wide,
    input  logic          page_mode,
    input  logic [DW-1:0] ptr_hi,
    input  logic [DW-1:0] latch,
    output logic [DW-1:0] hi
);
    always_comb begin
        if (wide && !page_mode) hi = ptr_hi;
        else                    hi = latch;
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int SHORT_STROBE = 3,
    parameter int LONG_STROBE  = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        start,
    input  logic        stretch,
    output xbus_state_e state,
    output logic        strobe_last
);
    localparam int CW = $clog2(LONG_STROBE + 1);
    localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_STROBE - 1);
    localparam logic [CW-1:0] LONG_LOAD  = CW'(LONG_STROBE - 1);

    xbus_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            unique case (state_q)
                ST_IDLE:    if (start) state_d = ST_ALE;
                ST_ALE:     state_d = ST_ADDR;
                ST_ADDR: begin
                    state_d = ST_STROBE;
                    cnt_d   = stretch ? LONG_LOAD : SHORT_LOAD;
                end
                ST_STROBE: begin
                    if (cnt_q == '0) state_d = ST_RECOVER;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                ST_RECOVER: state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state       = state_q;
    assign strobe_last = (state_q == ST_STROBE) && (cnt_q == '0);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SHORT_STROBE = 3,
    parameter int LONG_STROBE  = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbl_speed,
    input  logic          stretch_en,
    input  logic          page_mode,
    input  logic [DW-1:0] port2_latch,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_wide,
    input  logic [DW-1:0] req_lo,
    input  logic [DW-1:0] req_hi,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    input  logic [DW-1:0] p0_in,
    output logic [DW-1:0] p2_out
);
    logic          tick;
    logic          accept;
    logic          strobe_last;
    xbus_state_e   state;
    logic [DW-1:0] hi_sel;

    logic          wr_q;
    logic          stretch_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          done_q;

    xbus_tick u_tick (
        .clk       (clk),
        .rst       (rst),
        .dbl_speed (dbl_speed),
        .tick      (tick)
    );

    xbus_hi_sel #(.DW(DW)) u_hi_sel (
        .wide      (req_wide),
        .page_mode (page_mode),
        .ptr_hi    (req_hi),
        .latch     (port2_latch),
        .hi        (hi_sel)
    );

    assign accept = tick && (state == ST_IDLE) && req_valid;

    xbus_seq #(
        .SHORT_STROBE (SHORT_STROBE),
        .LONG_STROBE  (LONG_STROBE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .start       (req_valid),
        .stretch     (stretch_q),
        .state       (state),
        .strobe_last (strobe_last)
    );

    // request capture at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= 1'b0;
            stretch_q <= 1'b0;
            lo_q      <= '0;
            hi_q      <= '0;
            wdata_q   <= '0;
        end else if (accept) begin
            wr_q      <= req_write;
            stretch_q <= stretch_en;
            lo_q      <= req_lo;
            hi_q      <= hi_sel;
            wdata_q   <= req_wdata;
        end
    end

    // read sample on the last strobe bus clock, completion pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (tick && strobe_last && !wr_q) rdata_q <= p0_in;
            done_q <= tick && (state == ST_RECOVER);
        end
    end

    // bus outputs from state
    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        p0_oe  = 1'b0;
        p0_out = wdata_q;
        p2_out = hi_q;
        unique case (state)
            ST_IDLE: begin
                p2_out = port2_latch;
            end
            ST_ALE: begin
                ale    = 1'b1;
                p0_oe  = 1'b1;
                p0_out = lo_q;
            end
            ST_ADDR: begin
                p0_oe  = 1'b1;
                p0_out = lo_q;
            end
            ST_STROBE: begin
                rd_n  = wr_q;
                wr_n  = !wr_q;
                p0_oe = wr_q;
            end
            ST_RECOVER: begin
                p0_oe = wr_q;
            end
            default: begin
                p2_out = port2_latch;
            end
        endcase
    end

    assign busy  = (state != ST_IDLE);
    assign done  = done_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          ale,
    input logic          rd_n,
    input logic          wr_n,
    input logic          p0_oe,
    input logic [DW-1:0] p2_out
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        rd_n || wr_n); // R5
    AST_NO_STROBE_WITH_ALE: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n)); // R5
    AST_ALE_DRIVES_PORT: assert property (@(posedge clk) disable iff (rst)
        ale |-> p0_oe); // R3
    AST_WRITE_DRIVES_PORT: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> p0_oe); // R6
    AST_READ_RELEASES_PORT: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !p0_oe); // R7
    AST_P2_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(p2_out)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R11
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .p0_oe  (p0_oe),
    .p2_out (p2_out)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dbl_speed = 1'b0, stretch_en = 1'b0, page_mode = 1'b0;
    logic [7:0] port2_latch = 8'h00;
    logic       req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [7:0] req_lo = '0, req_hi = '0, req_wdata = '0, p0_in = '0;
    logic       busy, done, ale, rd_n, wr_n, p0_oe;
    logic [7:0] rdata, p0_out, p2_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xbus_ctrl uut (
        .clk(clk), .rst(rst), .dbl_speed(dbl_speed), .stretch_en(stretch_en),
        .page_mode(page_mode), .port2_latch(port2_latch), .req_valid(req_valid),
        .req_write(req_write), .req_wide(req_wide), .req_lo(req_lo), .req_hi(req_hi),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in),
        .p2_out(p2_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input int idx, input bit dbl, input bit str, input bit wr,
                           input bit wide, input bit pg);
        int div, s, t, k, wait_n;
        logic [7:0] lo, hi, latch, wd, good, bad, p2e;
        bit started;
        div   = dbl ? 1 : 2;
        s     = str ? 15 : 3;
        t     = 3 + s;
        lo    = 8'(idx * 29 + 17);
        hi    = 8'(idx * 71 + 3);
        latch = 8'(idx * 13 + 130);
        wd    = 8'(idx * 37 + 5);
        good  = 8'(idx * 53 + 9);
        bad   = ~good;
        p2e   = (wide && !pg) ? hi : latch;

        @(negedge clk);
        dbl_speed = dbl; stretch_en = str; page_mode = pg; port2_latch = latch;
        req_write = wr; req_wide = wide; req_lo = lo; req_hi = hi; req_wdata = wd;
        p0_in = bad; req_valid = 1'b1;

        started = 1'b0;
        wait_n  = 0;
        while (!started && wait_n < 10) begin
            @(negedge clk);
            if (busy) started = 1'b1;
            wait_n++;
        end
        chk(started, "R2 transfer start", int'(started), 1);
        if (!started) begin
            req_valid = 1'b0;
            return;
        end

        for (k = 0; k <= t * div + 1; k++) begin
            int cpu;
            bit strobe_e, oe_e;
            if (k > 0) @(negedge clk);
            cpu = k / div;
            if (k < t * div) begin
                strobe_e = (cpu >= 2) && (cpu < 2 + s);
                oe_e     = (cpu < 2) || wr;
                chk(busy == 1'b1, "R2/R4 busy during transfer", int'(busy), 1);
                chk(ale == (cpu == 0), "R3 ale timing", int'(ale), int'(cpu == 0));
                chk(rd_n == !(strobe_e && !wr), "R4 rd_n timing", int'(rd_n), int'(!(strobe_e && !wr)));
                chk(wr_n == !(strobe_e && wr), "R4 wr_n timing", int'(wr_n), int'(!(strobe_e && wr)));
                chk(rd_n || wr_n, "R5 both strobes low", int'({rd_n, wr_n}), 3);
                chk(!(ale && !(rd_n && wr_n)), "R5 strobe with ale", int'(ale), 0);
                if (cpu < 2) begin
                    chk(p0_oe && p0_out == lo, "R3 address on shared port", int'(p0_out), int'(lo));
                end else if (wr) begin
                    chk(p0_oe && p0_out == wd, "R6 write data driven", int'({p0_oe, p0_out}), int'({1'b1, wd}));
                end else begin
                    chk(p0_oe == 1'b0, "R7 port released on read", int'(p0_oe), 0);
                end
                chk(p0_oe == oe_e, "R6/R7 port enable", int'(p0_oe), int'(oe_e));
                if (k >= 2)
                    chk(p2_out == p2e, "R10 high byte held", int'(p2_out), int'(p2e));
                else if (wide)
                    chk(p2_out == p2e, "R9 high byte pointer form", int'(p2_out), int'(p2e));
                else
                    chk(p2_out == p2e, "R8 high byte indexed form", int'(p2_out), int'(p2e));
                chk(done == 1'b0, "R11 no done while busy", int'(done), 0);
            end else if (k == t * div) begin
                chk(busy == 1'b0, "R2/R4 busy length", int'(busy), 0);
                chk(done == 1'b1, "R11 done after busy", int'(done), 1);
                if (!wr) chk(rdata == good, "R7 read data", int'(rdata), int'(good));
            end else begin
                chk(done == 1'b0, "R11 done width", int'(done), 0);
            end
            // stimulus after sampling
            if (k == 0) begin
                req_lo = ~lo; req_hi = ~hi; req_wdata = ~wd; req_write = !wr;
            end
            if (k == 1) port2_latch = ~latch;
            if (k == 3) req_valid = 1'b0;
            if (k == (1 + s) * div) p0_in = good;
            if (k == (2 + s) * div) p0_in = bad;
        end

        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R12 request during busy ignored", int'(busy), 0);
        end
        port2_latch = latch;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(ale == 1'b0 && rd_n && wr_n && !p0_oe && !busy && !done,
            "R1 outputs in reset", int'({ale, rd_n, wr_n, p0_oe, busy, done}), 6'b011000);
        rst = 1'b0;
        port2_latch = 8'hC3;
        repeat (3) @(negedge clk);
        chk(ale == 1'b0 && rd_n && wr_n && !p0_oe && !busy && !done,
            "R1 idle outputs", int'({ale, rd_n, wr_n, p0_oe, busy, done}), 6'b011000);
        chk(p2_out == 8'hC3, "R1 idle high port", int'(p2_out), 8'hC3);

        for (int i = 0; i < 32; i++)
            run_txn(i, i[0], i[1], i[2], i[3], i[4]);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule